// File: doc/BRIEF.md
# Three-Mode UART Baud Tick Generator

This block turns a reference clock into the two timing strobes that a serial receive and transmit engine needs. An oversample strobe marks each sampling slot inside a bit. A bit strobe marks each bit boundary. The main divisor A is 16 bits wide and is presented as two bytes. A second, 4-bit divisor B sets a programmable oversampling ratio.

Two mode inputs choose how the bit time is formed:

- Fixed sixteen-times oversampling: one bit lasts 16 × (A+2) clocks.
- Programmable oversampling: one bit lasts (B+1) × (A+2) clocks.
- Direct division with no oversampling: one bit lasts A+2 clocks.

While the infrared function is selected, the programmable divider is forced off and the block runs in fixed sixteen-times mode.

The divisor settings are plain inputs that are sampled every clock. Any change to A, B or a mode input restarts both internal counters from zero. A registered flag reports settings that break the limits of the selected mode. The strobes keep running even while that flag is set.

Top module: `baud3_gen`

## Requirements
- R1: While reset is high and on the first clock after reset, both strobes are low. With the settings held through reset, the first oversample strobe is high after the (A+2)-th rising edge with reset low.
- R2: The oversample strobe is one clock wide and repeats every A+2 clocks, where A = {div_a_hi, div_a_lo}.
- R3: With xdiv_en low, the bit strobe repeats every 16 × (A+2) clocks.
- R4: With xdiv_en high and div_one low, the bit strobe repeats every (B+1) × (A+2) clocks.
- R5: With xdiv_en high and div_one high, the bit strobe repeats every A+2 clocks, coincides with every oversample strobe, and div_b has no effect on the output timing.
- R6: With irda_sel high, the block times as in R3 whatever xdiv_en and div_one are, and bad_cfg stays low.
- R7: The bit strobe is never high in a clock where the oversample strobe is low.
- R8: When any setting changes, the rising edge that first sees the new value restarts both counters. The next oversample strobe follows A+2 edges later, and the next bit strobe follows M × (A+2) edges later, where M is 16, B+1 or 1.
- R9: bad_cfg is high one clock after the settings select programmable oversampling with B < 8, or direct division with A < 3. It is low for any other settings, and the strobes keep running while it is high.
- R10: The high byte div_a_hi forms bits 15:8 of A and the low byte div_a_lo forms bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_a_lo | input | 8 | Main divisor, low byte |
| div_a_hi | input | 8 | Main divisor, high byte |
| div_b | input | 4 | Oversampling divisor B |
| xdiv_en | input | 1 | Enables the programmable divider path |
| div_one | input | 1 | With xdiv_en high, selects direct division |
| irda_sel | input | 1 | Infrared function selected; forces fixed 16x mode |
| os_tick | output | 1 | One-clock oversample strobe |
| baud_tick | output | 1 | One-clock bit strobe |
| bad_cfg | output | 1 | Settings violate the limits of the selected mode |

## Verification
The bench steps through a table of settings that covers the smallest main divisor, a divisor that needs the high byte, programmable ratios on both sides of the B limit, and direct division both with a legal A and with A below its limit. Measuring the delay to the first oversample strobe separates a correct A+2 period from an A+1 or A+3 period. Measuring the delay to the first two bit strobes separates the three multipliers from each other and shows that each change restarts the counters. The infrared rows set the divider mode inputs together with settings that would otherwise be flagged, so the bench can tell a working mode override from an ignored one. Directed tests then check reset release and a change made halfway through a count.

// File: rtl/baud3_pkg.sv
package baud3_pkg;
  typedef enum logic [1:0] {
    BM_X16    = 2'd0,
    BM_XB     = 2'd1,
    BM_DIRECT = 2'd2
  } bmode_e;
endpackage

// File: rtl/baud3_mode_dec.sv
module baud3_mode_dec
  import baud3_pkg::*;
#(
  parameter int A_W      = 16,
  parameter int B_W      = 4,
  parameter int OS_FIXED = 16,
  parameter int B_MIN    = 8,
  parameter int A_MIN    = 3,
  parameter int M_W      = 5
) (
  input  logic [A_W-1:0] a_val,
  input  logic [B_W-1:0] b_val,
  input  logic           xdiv_en,
  input  logic           div_one,
  input  logic           irda_sel,
  output bmode_e         mode,
  output logic [M_W-1:0] m_val,
  output logic           illegal
);
  logic xen_eff;

  // The infrared function forces the programmable divider off.
  assign xen_eff = xdiv_en & ~irda_sel;

  always_comb begin
    if (!xen_eff)     mode = BM_X16;
    else if (div_one) mode = BM_DIRECT;
    else              mode = BM_XB;
  end

  always_comb begin
    case (mode)
      BM_XB:     m_val = M_W'(b_val) + M_W'(1);
      BM_DIRECT: m_val = M_W'(1);
      default:   m_val = M_W'(OS_FIXED);
    endcase
  end

  always_comb begin
    case (mode)
      BM_XB:     illegal = (b_val < B_W'(B_MIN));
      BM_DIRECT: illegal = (a_val < A_W'(A_MIN));
      default:   illegal = 1'b0;
    endcase
  end
endmodule

// File: rtl/baud3_prescale.sv
module baud3_prescale #(
  parameter int A_W    = 16,
  parameter int OFFSET = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           restart,
  input  logic [A_W-1:0] a_val,
  output logic           os_hit,
  output logic           os_tick
);
  localparam int P_W = A_W + 1;

  logic [P_W-1:0] cnt;
  logic [P_W-1:0] last;

  // One oversample period is A + OFFSET clocks.
  assign last   = {1'b0, a_val} + P_W'(OFFSET) - P_W'(1);
  assign os_hit = !restart && (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      os_tick <= 1'b0;
    end else if (restart) begin
      cnt     <= '0;
      os_tick <= 1'b0;
    end else begin
      os_tick <= os_hit;
      cnt     <= os_hit ? '0 : cnt + P_W'(1);
    end
  end

  p_os_single_r2: assert property (@(posedge clk) disable iff (rst)
    os_tick |=> !os_tick);

  p_restart_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    restart |=> !os_tick);
endmodule

// File: rtl/baud3_bitcnt.sv
module baud3_bitcnt #(
  parameter int M_W = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           restart,
  input  logic           os_hit,
  input  logic [M_W-1:0] m_val,
  output logic           baud_tick
);
  logic [M_W-1:0] bcnt;
  logic           wrap;

  assign wrap = (bcnt >= m_val - M_W'(1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      bcnt      <= '0;
      baud_tick <= 1'b0;
    end else if (os_hit) begin
      bcnt      <= wrap ? '0 : bcnt + M_W'(1);
      baud_tick <= wrap;
    end else begin
      baud_tick <= 1'b0;
    end
  end

  p_bcnt_range_r3: assert property (@(posedge clk) disable iff (rst || restart)
    bcnt < m_val);

  p_baud_from_os_r7: assert property (@(posedge clk) disable iff (rst)
    baud_tick |-> $past(os_hit));
endmodule

// File: rtl/baud3_gen.sv
module baud3_gen
  import baud3_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int B_W      = 4,
  parameter int OS_FIXED = 16,
  parameter int OFFSET   = 2,
  parameter int B_MIN    = 8,
  parameter int A_MIN    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] div_a_lo,
  input  logic [BYTE_W-1:0] div_a_hi,
  input  logic [B_W-1:0]    div_b,
  input  logic              xdiv_en,
  input  logic              div_one,
  input  logic              irda_sel,
  output logic              os_tick,
  output logic              baud_tick,
  output logic              bad_cfg
);
  localparam int A_W   = 2 * BYTE_W;
  localparam int M_MAX = ((1 << B_W) > OS_FIXED) ? (1 << B_W) : OS_FIXED;
  localparam int M_W   = $clog2(M_MAX + 1);
  localparam int CFG_W = A_W + B_W + 3;

  logic [A_W-1:0]   a_val;
  logic [CFG_W-1:0] cfg, cfg_q;
  logic             restart;
  bmode_e           mode;
  logic [M_W-1:0]   m_val;
  logic             illegal;
  logic             os_hit;

  assign a_val   = {div_a_hi, div_a_lo};
  assign cfg     = {a_val, div_b, xdiv_en, div_one, irda_sel};
  assign restart = (cfg != cfg_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= cfg;
      bad_cfg <= 1'b0;
    end else begin
      cfg_q   <= cfg;
      bad_cfg <= illegal;
    end
  end

  baud3_mode_dec #(
    .A_W(A_W), .B_W(B_W), .OS_FIXED(OS_FIXED),
    .B_MIN(B_MIN), .A_MIN(A_MIN), .M_W(M_W)
  ) u_dec (
    .a_val(a_val), .b_val(div_b), .xdiv_en(xdiv_en), .div_one(div_one),
    .irda_sel(irda_sel), .mode(mode), .m_val(m_val), .illegal(illegal)
  );

  baud3_prescale #(.A_W(A_W), .OFFSET(OFFSET)) u_pre (
    .clk(clk), .rst(rst), .restart(restart), .a_val(a_val),
    .os_hit(os_hit), .os_tick(os_tick)
  );

  baud3_bitcnt #(.M_W(M_W)) u_bit (
    .clk(clk), .rst(rst), .restart(restart), .os_hit(os_hit),
    .m_val(m_val), .baud_tick(baud_tick)
  );

  p_baud_with_os_r7: assert property (@(posedge clk) disable iff (rst)
    baud_tick |-> os_tick);

  p_direct_every_os_r5: assert property (@(posedge clk) disable iff (rst)
    (os_tick && $past(mode == BM_DIRECT) && !$past(restart)) |-> baud_tick);

  p_bad_xb_r9: assert property (@(posedge clk) disable iff (rst)
    (xdiv_en && !div_one && !irda_sel && div_b < B_W'(B_MIN)) |=> bad_cfg);

  p_irda_clean_r6: assert property (@(posedge clk) disable iff (rst)
    irda_sel |=> !bad_cfg);
endmodule

// File: tb/sim_baud3_gen.sv
module sim_baud3_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] div_a_lo = 8'd3, div_a_hi = 8'd0;
  logic [3:0] div_b = 4'd0;
  logic       xdiv_en = 1'b0, div_one = 1'b0, irda_sel = 1'b0;
  logic       os_tick, baud_tick, bad_cfg;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  baud3_gen u0 (
    .clk(clk), .rst(rst), .div_a_lo(div_a_lo), .div_a_hi(div_a_hi),
    .div_b(div_b), .xdiv_en(xdiv_en), .div_one(div_one), .irda_sel(irda_sel),
    .os_tick(os_tick), .baud_tick(baud_tick), .bad_cfg(bad_cfg)
  );

  localparam int NV = 10;
  localparam int VA[NV]    = '{0, 5, 1, 2, 4, 3, 1, 258, 4, 1};
  localparam int VB[NV]    = '{0, 0, 9, 15, 3, 2, 12, 0, 2, 0};
  localparam int VX[NV]    = '{0, 0, 1, 1, 1, 1, 1, 1, 1, 1};
  localparam int VO[NV]    = '{0, 0, 0, 0, 0, 1, 1, 1, 0, 1};
  localparam int VI[NV]    = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1};
  localparam int VM[NV]    = '{16, 16, 10, 16, 4, 1, 1, 1, 16, 16};
  localparam int VBAD[NV]  = '{0, 0, 0, 0, 1, 0, 1, 0, 0, 0};
  localparam string VREQ[NV] = '{"R3", "R3", "R4", "R4", "R9", "R5", "R9",
                                 "R10", "R6", "R6"};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int a, input int b, input int x,
                         input int o, input int i);
    @(negedge clk);
    div_a_lo = a[7:0];
    div_a_hi = a[15:8];
    div_b    = b[3:0];
    xdiv_en  = x[0];
    div_one  = o[0];
    irda_sel = i[0];
  endtask

  // Counts edges after the settings were driven, sampling at falling edges.
  task automatic measure(input int limit, output int f_os, output int b1,
                         output int b2, output int orphan);
    int n = 0;
    f_os = -1; b1 = -1; b2 = -1; orphan = 0;
    while (b2 < 0 && n < limit) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (os_tick && f_os < 0) f_os = n;
      if (baud_tick) begin
        if (!os_tick) orphan++;
        if (b1 < 0) b1 = n;
        else        b2 = n;
      end
    end
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual %0d expected below 150000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int f_os, b1, b2, orphan, p, m;
    // R1: reset state and release timing (A=3, fixed 16x mode)
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 os low in reset", int'(os_tick), 0);
    check("R1 baud low in reset", int'(baud_tick), 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 os low after reset", int'(os_tick), 0);
    check("R1 baud low after reset", int'(baud_tick), 0);
    f_os = 1;
    while (!os_tick && f_os < 50) begin
      @(posedge clk);
      @(negedge clk);
      f_os++;
    end
    check("R1 first os edge", f_os, 5);
    @(posedge clk);
    @(negedge clk);
    check("R2 os one clock wide", int'(os_tick), 0);

    // Table of settings; every row differs from the previous one, so a restart
    // occurs on the edge that first samples it (R8).
    for (int k = 0; k < NV; k++) begin
      set_cfg(VA[k], VB[k], VX[k], VO[k], VI[k]);
      p = VA[k] + 2;
      m = VM[k];
      measure(4 * m * p + 20, f_os, b1, b2, orphan);
      check({VREQ[k], " R2 first os"}, f_os, p + 1);
      check({VREQ[k], " R8 first baud"}, b1, m * p + 1);
      check({VREQ[k], " baud period"}, b2 - b1, m * p);
      check("R7 baud without os", orphan, 0);
      check({"R9 ", VREQ[k], " bad flag"}, int'(bad_cfg), VBAD[k]);
    end

    // R8: change made partway through a long count
    set_cfg(20, 0, 0, 0, 0);
    repeat (30) @(posedge clk);
    set_cfg(2, 0, 1, 1, 0);
    measure(100, f_os, b1, b2, orphan);
    check("R8 os after mid-count change", f_os, 5);
    check("R8 baud after mid-count change", b1, 5);
    check("R5 direct period", b2 - b1, 4);

    // R5: changing only B in direct mode keeps the same periods
    set_cfg(2, 9, 1, 1, 0);
    measure(100, f_os, b1, b2, orphan);
    check("R5 B ignored first baud", b1, 5);
    check("R5 B ignored period", b2 - b1, 4);

    // R9: flag clears one clock after legal settings are applied
    set_cfg(1, 0, 1, 1, 0);
    @(posedge clk);
    @(negedge clk);
    check("R9 flag set for A below limit", int'(bad_cfg), 1);
    set_cfg(1, 8, 1, 0, 0);
    @(posedge clk);
    @(negedge clk);
    check("R9 flag clear for B at limit", int'(bad_cfg), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule